// File: doc/BRIEF.md
# Hashed Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by combining two single-bit predictors through a third single-bit chooser. A per-address table remembers the last outcome of each branch slot. A history-correlated table remembers the last outcome seen under a given mix of address and recent global path. A chooser table says, for each hashed slot, which of the two has lately been right. The per-address table is indexed by word-address bits of the fetch address. The history-correlated table and the chooser share one index: those same address bits XORed with a shift register of recent resolved outcomes, zero-extended to the index width.

Fetch logic presents an address on the lookup side. In the same cycle it reads back the final direction, the two component directions, the chooser bit and both indices. It carries these along with the branch. When the branch resolves, the carried values and the real outcome come back on the update side as one valid/ready beat. The update side asserts ready whenever reset is low, so it never applies back-pressure. A beat is taken on any rising edge where valid and ready are both high. Lookups are combinational and carry no handshake. Restoring the history after a wrong prediction is left to the surrounding pipeline.

The parameters are widths: address, table index and history. The defaults are kept small for elaboration. An instance with a 14-bit index and an 11-bit history gives three tables of 16K bits.

Top module: `bp_tournament`

## Requirements
- R1: While reset is high, every table bit and every history bit is cleared. After reset, every lookup returns 0 for the final direction, both component directions and the chooser bit.
- R2: The per-address index equals fetch address bits [IDX_W+1:2].
- R3: The shared hashed index equals fetch address bits [IDX_W+1:2] XOR the history zero-extended to IDX_W bits. Index bits at HIST_W and above therefore equal the per-address index.
- R4: Each accepted update shifts the history left by one and places the actual outcome (1 = taken) in bit 0. The shift is visible on the next lookup.
- R5: Each accepted update writes the actual outcome into the per-address table at the returned per-address index. It also writes the outcome into the history-correlated table at the returned hashed index.
- R6: When the returned component directions differ, an accepted update writes the chooser bit at the returned hashed index. The bit becomes 1 if the history-correlated direction matched the outcome and 0 if the per-address direction did.
- R7: When the returned component directions agree, the chooser bit is left unchanged.
- R8: The final direction is the history-correlated direction when the chooser bit is 1, and the per-address direction when it is 0.
- R9: Update ready is high whenever reset is low. A cycle with update valid low changes no table and no history bit.
- R10: Fetch address bits [1:0], and bits above IDX_W+1, have no effect on any index or prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| look_addr | input | ADDR_W | Fetch address to predict |
| look_taken | output | 1 | Final predicted direction (1 = taken) |
| look_loc_idx | output | IDX_W | Per-address index used |
| look_hash_idx | output | IDX_W | Hashed index used |
| look_loc_dir | output | 1 | Per-address component direction |
| look_glb_dir | output | 1 | History-correlated component direction |
| look_use_glb | output | 1 | Chooser bit (1 = history-correlated) |
| upd_valid | input | 1 | Update beat present |
| upd_ready | output | 1 | Update accepted when high with valid |
| upd_loc_idx | input | IDX_W | Per-address index returned from lookup |
| upd_hash_idx | input | IDX_W | Hashed index returned from lookup |
| upd_loc_dir | input | 1 | Per-address direction returned from lookup |
| upd_glb_dir | input | 1 | History-correlated direction returned from lookup |
| upd_taken | input | 1 | Actual outcome (1 = taken) |

## Verification
A corrupted table bit or a wrong chooser bit shows up only at the next lookup of the same slot, as a wrong component or final direction. This can come many branches after the bad write, so the bench replays a recurring address stream against a model of all three tables. A wrong history bit shows at once on the very next lookup as a wrong hashed index. Because it also moves every later hashed lookup, one fault spreads across the rest of the stream. The reset and no-valid checks re-read slots already trained to 1, so a missed clear or a stray write becomes visible.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    SRC_LOCAL  = 1'b0,
    SRC_GLOBAL = 1'b1
  } bp_src_e;

  localparam int unsigned BP_NUM_TABLES = 3;
  localparam int unsigned BP_TAB_LOC    = 0;
  localparam int unsigned BP_TAB_GLB    = 1;
  localparam int unsigned BP_TAB_SEL    = 2;
endpackage

// File: rtl/bp_bit_table.sv
module bp_bit_table #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (wr_en) begin
      bits_q[wr_idx] <= wr_bit;
    end
  end

  assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= {hist_q[HIST_W-2:0], bit_in};
    end
  end

  assign hist = hist_q;
endmodule

// File: rtl/bp_index_gen.sv
module bp_index_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  loc_idx,
  output logic [IDX_W-1:0]  hash_idx
);
  localparam int unsigned PAD_W = IDX_W - HIST_W;

  logic [IDX_W-1:0] hist_ext;

  generate
    if (PAD_W == 0) begin : g_nopad
      assign hist_ext = hist;
    end else begin : g_pad
      assign hist_ext = {{PAD_W{1'b0}}, hist};
    end
  endgenerate

  assign loc_idx  = addr[IDX_W+1:2];
  assign hash_idx = addr[IDX_W+1:2] ^ hist_ext;
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
  import bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_taken,
  output logic [IDX_W-1:0]  look_loc_idx,
  output logic [IDX_W-1:0]  look_hash_idx,
  output logic              look_loc_dir,
  output logic              look_glb_dir,
  output logic              look_use_glb,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [IDX_W-1:0]  upd_loc_idx,
  input  logic [IDX_W-1:0]  upd_hash_idx,
  input  logic              upd_loc_dir,
  input  logic              upd_glb_dir,
  input  logic              upd_taken
);
  localparam int unsigned NT = BP_NUM_TABLES;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  loc_idx, hash_idx;
  logic              accept;
  bp_src_e           src;

  logic [IDX_W-1:0] rd_idx [NT];
  logic             rd_bit [NT];
  logic             wr_en  [NT];
  logic [IDX_W-1:0] wr_idx [NT];
  logic             wr_bit [NT];

  assign upd_ready = ~rst;
  assign accept    = upd_valid & upd_ready;

  bp_index_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) u_idx (
    .addr     (look_addr),
    .hist     (hist),
    .loc_idx  (loc_idx),
    .hash_idx (hash_idx)
  );

  bp_hist_reg #(
    .HIST_W (HIST_W)
  ) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (accept),
    .bit_in   (upd_taken),
    .hist     (hist)
  );

  always_comb begin
    rd_idx[BP_TAB_LOC] = loc_idx;
    rd_idx[BP_TAB_GLB] = hash_idx;
    rd_idx[BP_TAB_SEL] = hash_idx;

    wr_idx[BP_TAB_LOC] = upd_loc_idx;
    wr_idx[BP_TAB_GLB] = upd_hash_idx;
    wr_idx[BP_TAB_SEL] = upd_hash_idx;

    wr_en[BP_TAB_LOC]  = accept;
    wr_en[BP_TAB_GLB]  = accept;
    wr_en[BP_TAB_SEL]  = accept & (upd_loc_dir ^ upd_glb_dir);

    wr_bit[BP_TAB_LOC] = upd_taken;
    wr_bit[BP_TAB_GLB] = upd_taken;
    wr_bit[BP_TAB_SEL] = ~(upd_glb_dir ^ upd_taken);
  end

  generate
    for (genvar t = 0; t < NT; t++) begin : g_tab
      bp_bit_table #(
        .IDX_W (IDX_W)
      ) u_tab (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (rd_idx[t]),
        .rd_bit (rd_bit[t]),
        .wr_en  (wr_en[t]),
        .wr_idx (wr_idx[t]),
        .wr_bit (wr_bit[t])
      );
    end
  endgenerate

  assign src = bp_src_e'(rd_bit[BP_TAB_SEL]);

  always_comb begin
    look_loc_idx  = loc_idx;
    look_hash_idx = hash_idx;
    look_loc_dir  = rd_bit[BP_TAB_LOC];
    look_glb_dir  = rd_bit[BP_TAB_GLB];
    look_use_glb  = rd_bit[BP_TAB_SEL];
    look_taken    = (src == SRC_GLOBAL) ? rd_bit[BP_TAB_GLB] : rd_bit[BP_TAB_LOC];
  end
endmodule

// File: rtl/bp_tournament_chk.sv
module bp_tournament_chk #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             look_taken,
  input logic [IDX_W-1:0] look_loc_idx,
  input logic [IDX_W-1:0] look_hash_idx,
  input logic             look_loc_dir,
  input logic             look_glb_dir,
  input logic             look_use_glb,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic [IDX_W-1:0] upd_loc_idx,
  input logic [IDX_W-1:0] upd_hash_idx,
  input logic             upd_loc_dir,
  input logic             upd_glb_dir,
  input logic             upd_taken
);
  logic acc;
  assign acc = upd_valid & upd_ready;

  assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!look_taken && !look_loc_dir && !look_glb_dir && !look_use_glb));

  assert_hash_upper_R3: assert property (@(posedge clk) disable iff (rst)
    ((look_hash_idx ^ look_loc_idx) >> HIST_W) == '0);

  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (rst)
    acc |=> ((look_hash_idx[0] ^ look_loc_idx[0]) == $past(upd_taken)));

  assert_loc_write_R5: assert property (@(posedge clk) disable iff (rst)
    acc |=> ((look_loc_idx != $past(upd_loc_idx)) || (look_loc_dir == $past(upd_taken))));

  assert_glb_write_R5: assert property (@(posedge clk) disable iff (rst)
    acc |=> ((look_hash_idx != $past(upd_hash_idx)) || (look_glb_dir == $past(upd_taken))));

  assert_sel_write_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && (upd_loc_dir != upd_glb_dir)) |=>
      ((look_hash_idx != $past(upd_hash_idx)) ||
       (look_use_glb == ($past(upd_glb_dir) == $past(upd_taken)))));

  assert_ready_R9: assert property (@(posedge clk) disable iff (rst) upd_ready);
endmodule

bind bp_tournament bp_tournament_chk #(
  .IDX_W  (IDX_W),
  .HIST_W (HIST_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .look_taken    (look_taken),
  .look_loc_idx  (look_loc_idx),
  .look_hash_idx (look_hash_idx),
  .look_loc_dir  (look_loc_dir),
  .look_glb_dir  (look_glb_dir),
  .look_use_glb  (look_use_glb),
  .upd_valid     (upd_valid),
  .upd_ready     (upd_ready),
  .upd_loc_idx   (upd_loc_idx),
  .upd_hash_idx  (upd_hash_idx),
  .upd_loc_dir   (upd_loc_dir),
  .upd_glb_dir   (upd_glb_dir),
  .upd_taken     (upd_taken)
);

// File: tb/bp_tournament_tb.sv
module bp_tournament_tb;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned HIST_W = 8;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned NVEC   = 16;

  // each entry: {fetch address, actual outcome}
  localparam logic [ADDR_W:0] VEC [NVEC] = '{
    {32'h0000_1000, 1'b1}, {32'h0000_1000, 1'b1}, {32'h0000_1000, 1'b0},
    {32'h0000_2004, 1'b1}, {32'h0000_1000, 1'b1}, {32'h0000_2004, 1'b0},
    {32'h0000_3008, 1'b1}, {32'h0000_1000, 1'b0}, {32'h0000_300C, 1'b1},
    {32'h0000_2004, 1'b1}, {32'h0000_1000, 1'b1}, {32'h0000_3008, 1'b0},
    {32'h0000_1000, 1'b1}, {32'h0000_400C, 1'b1}, {32'h0000_2004, 1'b0},
    {32'h0000_1000, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] look_addr = '0;
  logic              look_taken, look_loc_dir, look_glb_dir, look_use_glb;
  logic [IDX_W-1:0]  look_loc_idx, look_hash_idx;
  logic              upd_valid = 1'b0;
  logic              upd_ready;
  logic [IDX_W-1:0]  upd_loc_idx = '0, upd_hash_idx = '0;
  logic              upd_loc_dir = 1'b0, upd_glb_dir = 1'b0, upd_taken = 1'b0;

  int checks = 0;
  int failures = 0;

  bit               m_loc [DEPTH];
  bit               m_glb [DEPTH];
  bit               m_sel [DEPTH];
  logic [HIST_W-1:0] m_hist;

  bp_tournament #(
    .ADDR_W (ADDR_W), .IDX_W (IDX_W), .HIST_W (HIST_W)
  ) u_dut (
    .clk (clk), .rst (rst), .look_addr (look_addr), .look_taken (look_taken),
    .look_loc_idx (look_loc_idx), .look_hash_idx (look_hash_idx),
    .look_loc_dir (look_loc_dir), .look_glb_dir (look_glb_dir),
    .look_use_glb (look_use_glb), .upd_valid (upd_valid), .upd_ready (upd_ready),
    .upd_loc_idx (upd_loc_idx), .upd_hash_idx (upd_hash_idx),
    .upd_loc_dir (upd_loc_dir), .upd_glb_dir (upd_glb_dir), .upd_taken (upd_taken)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < DEPTH; k++) begin
      m_loc[k] = 1'b0; m_glb[k] = 1'b0; m_sel[k] = 1'b0;
    end
    m_hist = '0;
  endtask

  // Drive a lookup, compare every output with the model, optionally resolve.
  task automatic lookup_and_resolve(input logic [ADDR_W-1:0] a, input bit t, input bit do_upd);
    int li, hi;
    bit ld, gd, sd;
    @(negedge clk);
    upd_valid = 1'b0;
    look_addr = a;
    #1;
    li = int'(a[IDX_W+1:2]);
    hi = li ^ int'(m_hist);
    ld = m_loc[li]; gd = m_glb[hi]; sd = m_sel[hi];
    chk(look_loc_idx == IDX_W'(li), "R2 local index", int'(look_loc_idx), li);
    chk(look_hash_idx == IDX_W'(hi), "R3 R4 hashed index", int'(look_hash_idx), hi);
    chk(look_loc_dir == ld, "R5 local entry", int'(look_loc_dir), int'(ld));
    chk(look_glb_dir == gd, "R5 global entry", int'(look_glb_dir), int'(gd));
    chk(look_use_glb == sd, "R6 R7 chooser bit", int'(look_use_glb), int'(sd));
    chk(look_taken == (sd ? gd : ld), "R8 final direction", int'(look_taken), int'(sd ? gd : ld));
    if (do_upd) begin
      upd_valid    = 1'b1;
      upd_loc_idx  = IDX_W'(li);
      upd_hash_idx = IDX_W'(hi);
      upd_loc_dir  = ld;
      upd_glb_dir  = gd;
      upd_taken    = t;
      @(posedge clk);
      m_loc[li] = t;
      m_glb[hi] = t;
      if (ld != gd) m_sel[hi] = (gd == t);
      m_hist = {m_hist[HIST_W-2:0], t};
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state, R9 ready
    chk(look_taken == 1'b0 && look_use_glb == 1'b0, "R1 reset outputs",
        int'({look_taken, look_use_glb}), 0);
    chk(upd_ready == 1'b1, "R9 ready after reset", int'(upd_ready), 1);

    // main stream from the vector table, walked twice
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < NVEC; i++) begin
        lookup_and_resolve(VEC[i][ADDR_W:1], VEC[i][0], 1'b1);
      end
    end

    // R10: low and high address bits do not alter the lookup
    lookup_and_resolve(32'h0000_1000, 1'b0, 1'b0);
    begin
      logic [IDX_W-1:0] l0, h0;
      bit p0;
      l0 = look_loc_idx; h0 = look_hash_idx; p0 = look_taken;
      @(negedge clk);
      look_addr = 32'hFFF0_1003;
      #1;
      chk(look_loc_idx == l0 && look_hash_idx == h0 && look_taken == p0,
          "R10 ignored address bits", int'(look_loc_idx), int'(l0));
    end

    // Train one slot to taken, then present an update beat with valid low
    lookup_and_resolve(32'h0000_5010, 1'b1, 1'b1);
    @(negedge clk);
    upd_valid    = 1'b0;
    upd_loc_idx  = IDX_W'(32'h0000_5010 >> 2);
    upd_hash_idx = '0;
    upd_taken    = 1'b0;
    upd_loc_dir  = 1'b1;
    upd_glb_dir  = 1'b0;
    look_addr    = 32'h0000_5010;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(look_loc_dir == 1'b1, "R9 no write without valid", int'(look_loc_dir), 1);
    chk(look_hash_idx == (IDX_W'(32'h0000_5010 >> 2) ^ IDX_W'(m_hist)),
        "R9 history held without valid", int'(look_hash_idx),
        int'(IDX_W'(32'h0000_5010 >> 2) ^ IDX_W'(m_hist)));

    // Reset mid-run clears trained entries and the history
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    #1;
    chk(look_loc_dir == 1'b0, "R1 local cleared", int'(look_loc_dir), 0);
    chk(look_hash_idx == look_loc_idx, "R1 history cleared", int'(look_hash_idx), int'(look_loc_idx));
    lookup_and_resolve(32'h0000_1000, 1'b0, 1'b0);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule